// File: doc/BRIEF.md
# Station Learning and Flow Classification Engine

This block sits at the ingress side of a layer-2 switch. For every frame header it receives (destination address, source address and the port the frame came in on) it does three things in one fixed-length lookup. It records which port the source station lives on. It turns the destination into a port mask: a single port for a known station, or every port but the ingress port for an unknown or broadcast destination. It also gives the frame a flow number, one per distinct source/destination pair, which a downstream scheduler uses to keep a separate queue for each conversation.

The switch is split across two identical instances, each serving half of the ports. Each time this instance learns a new station, or sees a known station move to another port, it emits a notification on a side channel for its peer. Notifications arriving from the peer are written into the local table. No entry ever expires, and frames are not stored here.

Top module: `mac_flow_lookup`

## Requirements
- R1: After reset, `hdrReady` and `peerReady` are 1, and `resValid` and `learnValid` are 0.
- R2: A unicast source address that is not in the table, arriving while the table has a free entry, is stored with its ingress port. `learnValid` pulses together with `resValid`, carrying that address and port.
- R3: A destination found in the table, on a port other than the ingress port, gives a mask with only the learned port's bit set. Bit i of the mask stands for port i.
- R4: A destination not in the table gives a mask with every port bit set except the ingress port's bit.
- R5: The destination FF:FF:FF:FF:FF:FF (all 48 bits one) always floods to every port except the ingress port, whatever the table holds.
- R6: A destination learned on the same port the frame arrived on gives an all-zero mask. The destination lookup uses the table as it stood before this frame's own source address is learned.
- R7: When a known source address arrives on a different port, its entry takes the new port and `learnValid` pulses. When it arrives on the same port, `learnValid` stays 0.
- R8: A peer update (`peerValid` and `peerReady` both 1) stores the address with the given port, or overwrites the port if the address is already present. It never raises `learnValid`. `peerReady` is 0 while a lookup is in progress.
- R9: A source address whose group bit is set (bit 40, the least significant bit of the first octet) is never learned and raises no notification.
- R10: A source/destination pair seen for the first time gets the next flow number, counting up from 1, and `resNewFlow` is 1. The same pair seen again returns the same number with `resNewFlow` at 0.
- R11: When flow numbers 1 to FLOWS-1 are all in use, a new pair returns flow 0 with `resOverflow` at 1 and `resNewFlow` at 0. Pairs that already have a number still return it.
- R12: When the station table is full, a new source address is not stored and raises no notification. Later frames addressed to it flood as in R4.
- R13: A header is accepted on a clock edge where `hdrValid` and `hdrReady` are both 1. `hdrReady` is 0 for the next cycle. `resValid` is 1 for exactly the one cycle that starts at the second edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hdrValid | input | 1 | Header presented |
| hdrReady | output | 1 | Engine can accept a header |
| hdrDa | input | ADDR_W | Destination address |
| hdrSa | input | ADDR_W | Source address |
| hdrPort | input | $clog2(NUM_PORTS) | Ingress port of the frame |
| peerValid | input | 1 | Peer learning update presented |
| peerReady | output | 1 | Peer update can be taken this cycle |
| peerAddr | input | ADDR_W | Station address from the peer |
| peerPort | input | $clog2(NUM_PORTS) | Port of that station |
| resValid | output | 1 | Lookup result valid (one cycle) |
| resMask | output | NUM_PORTS | Output port mask |
| resFlow | output | $clog2(FLOWS) | Flow number, 0 is the default flow |
| resNewFlow | output | 1 | Flow number was allocated by this lookup |
| resOverflow | output | 1 | No flow number was free |
| learnValid | output | 1 | Notification for the peer (one cycle) |
| learnAddr | output | ADDR_W | Learned or moved station address |
| learnPort | output | $clog2(NUM_PORTS) | Port of that station |

## Verification
The bench builds the engine with 4 ports, a 4-entry station table and 8 flow numbers. With these sizes the station table fills after one peer install and three local learns, and the flow numbers run out partway through a sweep over every source/destination combination. Moves, group source addresses, a full table, flow overflow, broadcast, and destinations on the ingress port all occur within a few dozen headers. Each result is compared with a small reference model in the bench that follows the requirements.

// File: rtl/mfl_pkg.sv
package mfl_pkg;

  // Strobes from the sequencer to the table datapath.
  typedef struct packed {
    logic capture;  // latch the incoming header
    logic commit;   // apply lookup decisions and register the result
    logic peerWr;   // install a peer learning update
  } mflStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOOK = 1'b1
  } mflState_t;

endpackage

// File: rtl/mfl_ctrl.sv
module mfl_ctrl
  import mfl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hdrValid,
  input  logic       peerValid,
  output logic       hdrReady,
  output logic       peerReady,
  output mflStrobe_t strb
);

  mflState_t state;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (hdrValid) state <= ST_LOOK;
        ST_LOOK: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Both inputs are open only while no lookup is pending, so table writes
  // from the peer never collide with a commit.
  assign hdrReady  = (state == ST_IDLE);
  assign peerReady = (state == ST_IDLE);

  always_comb begin
    strb.capture = hdrValid && hdrReady;
    strb.peerWr  = peerValid && peerReady;
    strb.commit  = (state == ST_LOOK);
  end

  // R13: an accepted header blocks both inputs for the following cycle
  p_busy_after_accept_r13: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrReady) |=> (!hdrReady && !peerReady));

  // R13: the busy cycle always ends after exactly one cycle
  p_busy_one_cycle_r13: assert property (@(posedge clk) disable iff (!rstN)
    !hdrReady |=> hdrReady);

endmodule

// File: rtl/mfl_dpath.sv
module mfl_dpath
  import mfl_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int ADDR_W       = 48,
  parameter int ADDR_ENTRIES = 32,
  parameter int FLOWS        = 256,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int FLOW_W = $clog2(FLOWS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mflStrobe_t           strb,
  input  logic [ADDR_W-1:0]    hdrDa,
  input  logic [ADDR_W-1:0]    hdrSa,
  input  logic [PORT_W-1:0]    hdrPort,
  input  logic [ADDR_W-1:0]    peerAddr,
  input  logic [PORT_W-1:0]    peerPort,
  output logic                 resValid,
  output logic [NUM_PORTS-1:0] resMask,
  output logic [FLOW_W-1:0]    resFlow,
  output logic                 resNewFlow,
  output logic                 resOverflow,
  output logic                 learnValid,
  output logic [ADDR_W-1:0]    learnAddr,
  output logic [PORT_W-1:0]    learnPort
);

  localparam int AIDX_W  = $clog2(ADDR_ENTRIES);
  localparam int ACNT_W  = $clog2(ADDR_ENTRIES + 1);
  localparam int FSLOTS  = FLOWS - 1;          // flow 0 is the default
  localparam int FIDX_W  = $clog2(FSLOTS);
  localparam int GRP_BIT = ADDR_W - 8;         // I/G bit of the first octet

  // ---------------- captured header ----------------
  logic [ADDR_W-1:0] daQ, saQ;
  logic [PORT_W-1:0] portQ;

  // ---------------- station table ----------------
  logic [ADDR_W-1:0]       stAddr [ADDR_ENTRIES];
  logic [PORT_W-1:0]       stPort [ADDR_ENTRIES];
  logic [ADDR_ENTRIES-1:0] stValid;
  logic [ACNT_W-1:0]       stFill;

  // ---------------- flow table ----------------
  logic [ADDR_W-1:0] fSa [FSLOTS];
  logic [ADDR_W-1:0] fDa [FSLOTS];
  logic [FSLOTS-1:0] fValid;
  logic [FLOW_W-1:0] fFill;

  logic [ADDR_ENTRIES-1:0] saHit, daHit, peerHit;
  logic [FSLOTS-1:0]       flowHit;

  for (genvar g = 0; g < ADDR_ENTRIES; g++) begin : g_stMatch
    assign saHit[g]   = stValid[g] && (stAddr[g] == saQ);
    assign daHit[g]   = stValid[g] && (stAddr[g] == daQ);
    assign peerHit[g] = stValid[g] && (stAddr[g] == peerAddr);
  end

  for (genvar g = 0; g < FSLOTS; g++) begin : g_flowMatch
    assign flowHit[g] = fValid[g] && (fSa[g] == saQ) && (fDa[g] == daQ);
  end

  function automatic logic [AIDX_W-1:0] stFirst(input logic [ADDR_ENTRIES-1:0] v);
    stFirst = '0;
    for (int i = ADDR_ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) stFirst = AIDX_W'(i);
    end
  endfunction

  function automatic logic [FIDX_W-1:0] flowFirst(input logic [FSLOTS-1:0] v);
    flowFirst = '0;
    for (int i = FSLOTS - 1; i >= 0; i--) begin
      if (v[i]) flowFirst = FIDX_W'(i);
    end
  endfunction

  // ---------------- lookup decisions ----------------
  logic [AIDX_W-1:0]    saIdx, daIdx, peerIdx, fillIdx;
  logic [FIDX_W-1:0]    flowIdx, flowFillIdx;
  logic                 stFull, saGroup, learnMove, learnNew;
  logic                 daBcast, flowAny, flowFull;
  logic [PORT_W-1:0]    saOldPort, daPort;
  logic [NUM_PORTS-1:0] ingMask, floodMask, nextMask;
  logic [FLOW_W-1:0]    nextFlow;

  assign saIdx       = stFirst(saHit);
  assign daIdx       = stFirst(daHit);
  assign peerIdx     = stFirst(peerHit);
  assign fillIdx     = AIDX_W'(stFill);
  assign flowIdx     = flowFirst(flowHit);
  assign flowFillIdx = FIDX_W'(fFill);

  assign stFull    = (stFill == ACNT_W'(ADDR_ENTRIES));
  assign saGroup   = saQ[GRP_BIT];
  assign saOldPort = stPort[saIdx];
  assign learnMove = !saGroup && (|saHit) && (saOldPort != portQ);
  assign learnNew  = !saGroup && !(|saHit) && !stFull;

  assign daBcast   = &daQ;
  assign daPort    = stPort[daIdx];
  assign ingMask   = NUM_PORTS'(1) << portQ;
  assign floodMask = ~ingMask;

  always_comb begin
    if (daBcast || !(|daHit)) begin
      nextMask = floodMask;
    end else if (daPort == portQ) begin
      nextMask = '0;
    end else begin
      nextMask = NUM_PORTS'(1) << daPort;
    end
  end

  assign flowAny  = |flowHit;
  assign flowFull = (fFill == FLOW_W'(FSLOTS));
  always_comb begin
    if (flowAny)       nextFlow = FLOW_W'(flowIdx) + FLOW_W'(1);
    else if (flowFull) nextFlow = '0;
    else               nextFlow = fFill + FLOW_W'(1);
  end

  // ---------------- storage without reset ----------------
  always_ff @(posedge clk) begin
    if (strb.capture) begin
      daQ   <= hdrDa;
      saQ   <= hdrSa;
      portQ <= hdrPort;
    end
    if (strb.commit) begin
      if (learnMove) stPort[saIdx] <= portQ;
      if (learnNew) begin
        stAddr[fillIdx] <= saQ;
        stPort[fillIdx] <= portQ;
      end
      if (!flowAny && !flowFull) begin
        fSa[flowFillIdx] <= saQ;
        fDa[flowFillIdx] <= daQ;
      end
      resMask   <= nextMask;
      resFlow   <= nextFlow;
      learnAddr <= saQ;
      learnPort <= portQ;
    end
    if (strb.peerWr) begin
      if (|peerHit) begin
        stPort[peerIdx] <= peerPort;
      end else if (!stFull) begin
        stAddr[fillIdx] <= peerAddr;
        stPort[fillIdx] <= peerPort;
      end
    end
  end

  // ---------------- state with reset ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stValid     <= '0;
      stFill      <= '0;
      fValid      <= '0;
      fFill       <= '0;
      resValid    <= 1'b0;
      resNewFlow  <= 1'b0;
      resOverflow <= 1'b0;
      learnValid  <= 1'b0;
    end else begin
      resValid   <= strb.commit;
      learnValid <= strb.commit && (learnMove || learnNew);
      if (strb.commit) begin
        resNewFlow  <= !flowAny && !flowFull;
        resOverflow <= !flowAny && flowFull;
        if (learnNew) begin
          stValid[fillIdx] <= 1'b1;
          stFill           <= stFill + ACNT_W'(1);
        end
        if (!flowAny && !flowFull) begin
          fValid[flowFillIdx] <= 1'b1;
          fFill               <= fFill + FLOW_W'(1);
        end
      end
      if (strb.peerWr && !(|peerHit) && !stFull) begin
        stValid[fillIdx] <= 1'b1;
        stFill           <= stFill + ACNT_W'(1);
      end
    end
  end

  // R4/R5/R6: a result never sends the frame back out of its ingress port
  p_no_hairpin_r4: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> !resMask[portQ]);

  // R9: notifications never carry a group address
  p_learn_unicast_r9: assert property (@(posedge clk) disable iff (!rstN)
    learnValid |-> !learnAddr[GRP_BIT]);

  // R10: a freshly allocated flow is never the default flow
  p_new_flow_nonzero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resNewFlow) |-> (resFlow != '0 && !resOverflow));

  // R11: overflow always falls back to the default flow
  p_overflow_default_r11: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && resOverflow) |-> (resFlow == '0 && !resNewFlow));

  // R12: the station fill count never passes the table size
  p_fill_bound_r12: assert property (@(posedge clk) disable iff (!rstN)
    stFill <= ACNT_W'(ADDR_ENTRIES));

  // R12: a full table admits no new station entry
  p_full_stays_r12: assert property (@(posedge clk) disable iff (!rstN)
    stFull |=> $stable(stFill));

endmodule

// File: rtl/mac_flow_lookup.sv
module mac_flow_lookup
  import mfl_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int ADDR_W       = 48,
  parameter int ADDR_ENTRIES = 32,
  parameter int FLOWS        = 256,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int FLOW_W = $clog2(FLOWS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hdrValid,
  output logic                 hdrReady,
  input  logic [ADDR_W-1:0]    hdrDa,
  input  logic [ADDR_W-1:0]    hdrSa,
  input  logic [PORT_W-1:0]    hdrPort,
  input  logic                 peerValid,
  output logic                 peerReady,
  input  logic [ADDR_W-1:0]    peerAddr,
  input  logic [PORT_W-1:0]    peerPort,
  output logic                 resValid,
  output logic [NUM_PORTS-1:0] resMask,
  output logic [FLOW_W-1:0]    resFlow,
  output logic                 resNewFlow,
  output logic                 resOverflow,
  output logic                 learnValid,
  output logic [ADDR_W-1:0]    learnAddr,
  output logic [PORT_W-1:0]    learnPort
);

  mflStrobe_t strb;

  mfl_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hdrValid  (hdrValid),
    .peerValid (peerValid),
    .hdrReady  (hdrReady),
    .peerReady (peerReady),
    .strb      (strb)
  );

  mfl_dpath #(
    .NUM_PORTS    (NUM_PORTS),
    .ADDR_W       (ADDR_W),
    .ADDR_ENTRIES (ADDR_ENTRIES),
    .FLOWS        (FLOWS)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .hdrDa       (hdrDa),
    .hdrSa       (hdrSa),
    .hdrPort     (hdrPort),
    .peerAddr    (peerAddr),
    .peerPort    (peerPort),
    .resValid    (resValid),
    .resMask     (resMask),
    .resFlow     (resFlow),
    .resNewFlow  (resNewFlow),
    .resOverflow (resOverflow),
    .learnValid  (learnValid),
    .learnAddr   (learnAddr),
    .learnPort   (learnPort)
  );

  // R13: the result arrives exactly two edges after acceptance
  p_result_latency_r13: assert property (@(posedge clk) disable iff (!rstN)
    (hdrValid && hdrReady) |=> ##1 resValid);

  // R13: results are single-cycle pulses
  p_result_pulse_r13: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

endmodule

// File: tb/mac_flow_lookup_bench.sv
module mac_flow_lookup_bench;

  localparam int NP = 4;
  localparam int NE = 4;
  localparam int NF = 8;
  localparam int PW = $clog2(NP);
  localparam int FW = $clog2(NF);
  localparam logic [47:0] BCAST = '1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hdrValid = 1'b0, hdrReady;
  logic [47:0]   hdrDa = '0, hdrSa = '0;
  logic [PW-1:0] hdrPort = '0;
  logic          peerValid = 1'b0, peerReady;
  logic [47:0]   peerAddr = '0;
  logic [PW-1:0] peerPort = '0;
  logic          resValid, resNewFlow, resOverflow, learnValid;
  logic [NP-1:0] resMask;
  logic [FW-1:0] resFlow;
  logic [47:0]   learnAddr;
  logic [PW-1:0] learnPort;

  always #10 clk = ~clk;  // 50 MHz

  mac_flow_lookup #(.NUM_PORTS(NP), .ADDR_W(48), .ADDR_ENTRIES(NE), .FLOWS(NF)) u_mac_flow_lookup (
    .clk(clk), .rstN(rstN),
    .hdrValid(hdrValid), .hdrReady(hdrReady), .hdrDa(hdrDa), .hdrSa(hdrSa), .hdrPort(hdrPort),
    .peerValid(peerValid), .peerReady(peerReady), .peerAddr(peerAddr), .peerPort(peerPort),
    .resValid(resValid), .resMask(resMask), .resFlow(resFlow), .resNewFlow(resNewFlow),
    .resOverflow(resOverflow), .learnValid(learnValid), .learnAddr(learnAddr), .learnPort(learnPort)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  // reference model
  logic [47:0] mAddr [NE];
  int          mPort [NE];
  int          mCnt = 0;
  logic [47:0] mFs [NF];
  logic [47:0] mFd [NF];
  int          mFcnt = 0;

  function automatic logic [47:0] st(input int i);
    return {8'h02, 32'h0, 8'(i)};
  endfunction

  function automatic int findSt(input logic [47:0] a);
    for (int i = 0; i < mCnt; i++) if (mAddr[i] == a) return i;
    return -1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic peerPut(input logic [47:0] a, input int p);
    int idx;
    @(negedge clk);
    chk(peerReady == 1'b1, "R8", "peerReady idle", 64'(peerReady), 64'd1);
    peerValid = 1'b1; peerAddr = a; peerPort = PW'(p);
    @(negedge clk);
    peerValid = 1'b0;
    chk(learnValid == 1'b0, "R8", "no echo of peer update", 64'(learnValid), 64'd0);
    idx = findSt(a);
    if (idx >= 0) mPort[idx] = p;
    else if (mCnt < NE) begin mAddr[mCnt] = a; mPort[mCnt] = p; mCnt++; end
  endtask

  task automatic sendHdr(input logic [47:0] da, input logic [47:0] sa, input int p,
                         input string maskTagOverride);
    int saI, daI, fI, full;
    logic [NP-1:0] eMask;
    string mTag, lTag, fTag;
    bit eLearn, eNew, eOvf;
    int eFlow;
    full = (1 << NP) - 1;
    saI = findSt(sa);
    daI = findSt(da);
    // destination mask from table before learning
    if (da == BCAST) begin
      eMask = NP'(full & ~(1 << p)); mTag = "R5";
    end else if (daI >= 0 && mPort[daI] == p) begin
      eMask = '0; mTag = "R6";
    end else if (daI >= 0) begin
      eMask = NP'(1 << mPort[daI]); mTag = "R3";
    end else begin
      eMask = NP'(full & ~(1 << p)); mTag = (mCnt == NE) ? "R12" : "R4";
    end
    if (maskTagOverride != "") mTag = maskTagOverride;
    // learning
    eLearn = 1'b0;
    if (sa[40]) begin
      lTag = "R9";
    end else if (saI >= 0) begin
      lTag = "R7";
      if (mPort[saI] != p) begin eLearn = 1'b1; mPort[saI] = p; end
    end else if (mCnt < NE) begin
      lTag = "R2"; eLearn = 1'b1; mAddr[mCnt] = sa; mPort[mCnt] = p; mCnt++;
    end else begin
      lTag = "R12";
    end
    // flow numbering
    fI = -1;
    for (int i = 0; i < mFcnt; i++) if (mFs[i] == sa && mFd[i] == da) fI = i;
    eNew = 1'b0; eOvf = 1'b0;
    if (fI >= 0) begin
      eFlow = fI + 1; fTag = "R10";
    end else if (mFcnt < NF - 1) begin
      mFs[mFcnt] = sa; mFd[mFcnt] = da; mFcnt++; eFlow = mFcnt; eNew = 1'b1; fTag = "R10";
    end else begin
      eFlow = 0; eOvf = 1'b1; fTag = "R11";
    end
    // drive
    @(negedge clk);
    chk(hdrReady == 1'b1, "R13", "hdrReady before accept", 64'(hdrReady), 64'd1);
    hdrValid = 1'b1; hdrDa = da; hdrSa = sa; hdrPort = PW'(p);
    @(negedge clk);
    hdrValid = 1'b0;
    chk(hdrReady == 1'b0, "R13", "hdrReady busy", 64'(hdrReady), 64'd0);
    chk(peerReady == 1'b0, "R8", "peerReady busy", 64'(peerReady), 64'd0);
    chk(resValid == 1'b0, "R13", "resValid early", 64'(resValid), 64'd0);
    @(negedge clk);
    chk(resValid == 1'b1, "R13", "resValid", 64'(resValid), 64'd1);
    chk(resMask == eMask, mTag, "mask", 64'(resMask), 64'(eMask));
    chk(resFlow == FW'(eFlow), fTag, "flow", 64'(resFlow), 64'(eFlow));
    chk(resNewFlow == eNew, "R10", "newFlow", 64'(resNewFlow), 64'(eNew));
    chk(resOverflow == eOvf, "R11", "overflow", 64'(resOverflow), 64'(eOvf));
    chk(learnValid == eLearn, lTag, "learnValid", 64'(learnValid), 64'(eLearn));
    if (eLearn) begin
      chk(learnAddr == sa, lTag, "learnAddr", learnAddr, sa);
      chk(learnPort == PW'(p), lTag, "learnPort", 64'(learnPort), 64'(p));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(hdrReady == 1'b1, "R1", "hdrReady", 64'(hdrReady), 64'd1);
    chk(peerReady == 1'b1, "R1", "peerReady", 64'(peerReady), 64'd1);
    chk(resValid == 1'b0, "R1", "resValid", 64'(resValid), 64'd0);
    chk(learnValid == 1'b0, "R1", "learnValid", 64'(learnValid), 64'd0);
    rstN = 1'b1;

    // R8: peer installs station 7 on port 2
    peerPut(st(7), 2);
    // R2 learning, R3/R6 against the peer entry
    for (int i = 0; i < 3; i++) sendHdr(st(7), st(i), i, (i == 2) ? "R6" : "R8");
    // sweep every pair, including broadcast; flow numbers run out (R11)
    for (int s = 0; s < 3; s++)
      for (int d = 0; d < 5; d++)
        sendHdr((d == 3) ? st(7) : (d == 4) ? BCAST : st(d), st(s), s, "");
    // R7: station 0 moves to port 3, then repeats on the same port
    sendHdr(st(1), st(0), 3, "");
    sendHdr(st(2), st(0), 3, "");
    // R9: group source address, destination on ingress port (R6)
    sendHdr(st(1), {8'h01, 40'h99}, 1, "");
    // R12: table full, new station not learned, later flooded
    sendHdr(st(1), st(5), 0, "");
    sendHdr(st(5), st(0), 3, "");
    // R8: peer moves station 1 to port 3
    peerPut(st(1), 3);
    sendHdr(st(1), st(2), 2, "R8");
    // R5: broadcast from a moved station
    sendHdr(BCAST, st(0), 3, "");

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule